// File: doc/BRIEF.md
# Windowed Bit-Error-Rate Alarm with Hysteresis

This block turns per-frame parity error counts into a degrade or fail alarm. Every frame strobe brings an error count from one of two parity sources. A control bit picks the source, either the section parity or the line parity. The block sums these counts over a measurement block of a programmable number of frames and grades each finished block as a hit or a miss. The alarm changes state once enough hits have gathered inside a window of a programmable number of blocks.

Declaring and removing the alarm use separate parameter sets. Each set has its own error threshold, block length in frames, hit count and window length in blocks. While the alarm is off, a block is a hit when its error sum reaches the declare threshold. While the alarm is on, a block is a hit when its error sum stays below the removal threshold. This M-of-B rule with two parameter sets gives the alarm hysteresis. With a 19-bit block length and a 12-bit window, one instance can be set for error rates anywhere from about 1e-3 to 1e-9.

Every change of the alarm state sets a sticky change flag. A one-cycle clear pulse resets the flag, and a mask bit gates the interrupt output.

Top module: `ber_hyst_detector`

## Requirements
- R1: While the alarm is off, a block of `set_frames` frames whose summed errors are greater than or equal to `set_thresh` is a hit. The alarm turns on in the cycle that the `set_hits`-th hit of the current window is counted.
- R2: When a window of `set_blocks` blocks (alarm off) or `clr_blocks` blocks (alarm on) ends without enough hits, the hit and block counts go back to zero and a new window starts.
- R3: While the alarm is on, a block of `clr_frames` frames whose summed errors are strictly less than `clr_thresh` is a hit. The alarm turns off when the `clr_hits`-th hit of the current window is counted.
- R4: Only the parameter set of the current state is used. When the state changes, the frame, error, block and hit counts all restart from zero, so no progress carries across the change.
- R5: `src_sel` = 0 takes the error count from `err_sec`, and `src_sel` = 1 takes it from `err_line`. The other input has no effect.
- R6: `chg_flag` goes to 1 on every alarm state change. It stays at 1 until a cycle with `chg_clr` = 1 and no state change.
- R7: `irq` equals `chg_flag` AND NOT `chg_mask`.
- R8: The per-block error sum saturates at 2^ACC_W-1 (255 by default) and does not wrap. A saturated sum is compared as 255.
- R9: A frame count, hit count or window length that is programmed as 0 acts as 1.
- R10: After reset `alarm`, `chg_flag` and `irq` are 0. `alarm` takes its new value at the clock edge that follows the edge sampling the last frame strobe of the deciding block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| err_sec | input | ERR_W (5) | Section parity error count of the frame |
| err_line | input | ERR_W (5) | Line parity error count of the frame |
| src_sel | input | 1 | 0: section parity, 1: line parity |
| set_thresh | input | L_W (4) | Declare: errors per block for a hit |
| set_frames | input | NS_W (19) | Declare: frames per block |
| set_hits | input | M_W (8) | Declare: hits needed in a window |
| set_blocks | input | B_W (12) | Declare: blocks per window |
| clr_thresh | input | L_W (4) | Remove: a hit needs fewer errors than this |
| clr_frames | input | NS_W (19) | Remove: frames per block |
| clr_hits | input | M_W (8) | Remove: hits needed in a window |
| clr_blocks | input | B_W (12) | Remove: blocks per window |
| chg_clr | input | 1 | Write-one pulse that clears the change flag |
| chg_mask | input | 1 | 1 masks the interrupt |
| alarm | output | 1 | Current alarm state |
| chg_flag | output | 1 | Sticky change-of-state flag |
| irq | output | 1 | Masked change interrupt |

## Verification
Assertions check four things on every cycle. The error sum stays saturated once it is full. Both window counts are zero after each state change. The change flag holds until it is cleared and is set whenever the alarm moves. The interrupt never fires while masked. Other behaviour can only be shown by the bench's frame sequences. These cover the hit grading against the two thresholds, a window that expires before it completes, the effect of the source select, a sum that would wrap below the removal threshold, and parameters programmed as zero.

// File: rtl/ber_hyst_pkg.sv
package ber_hyst_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ALARM = 1'b1
    } ber_state_e;

    localparam int DEF_ERR_W = 5;
    localparam int DEF_L_W   = 4;
    localparam int DEF_NS_W  = 19;
    localparam int DEF_M_W   = 8;
    localparam int DEF_B_W   = 12;
    localparam int DEF_ACC_W = 8;

endpackage

// File: rtl/ber_blk_acc.sv
// Per-block frame counter and saturating error accumulator with hit grading.
module ber_blk_acc #(
    parameter int ERR_W = 5,
    parameter int NS_W  = 19,
    parameter int L_W   = 4,
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             frame_stb,
    input  logic [ERR_W-1:0] err,
    input  logic [NS_W-1:0]  ns_len,
    input  logic [L_W-1:0]   l_thr,
    input  logic             in_alarm,
    output logic             blk_done,
    output logic             blk_hit
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    typedef struct packed {
        logic [NS_W-1:0]  fcnt;
        logic [ACC_W-1:0] acc;
        logic             done;
        logic             hit;
    } blk_t;

    blk_t r_q, r_d;

    logic [ACC_W:0]   sum_w;
    logic [ACC_W-1:0] sum_sat;
    logic             last_frame;
    logic             grade;

    always_comb begin
        sum_w      = {1'b0, r_q.acc} + (ACC_W+1)'(err);
        sum_sat    = sum_w[ACC_W] ? ACC_MAX : sum_w[ACC_W-1:0];
        last_frame = (({1'b0, r_q.fcnt} + (NS_W+1)'(1)) >= {1'b0, ns_len});
        grade      = in_alarm ? (sum_sat < ACC_W'(l_thr))
                              : (sum_sat >= ACC_W'(l_thr));

        r_d      = r_q;
        r_d.done = 1'b0;
        if (restart) begin
            r_d.fcnt = '0;
            r_d.acc  = '0;
            r_d.hit  = 1'b0;
        end else if (frame_stb) begin
            if (last_frame) begin
                r_d.fcnt = '0;
                r_d.acc  = '0;
                r_d.done = 1'b1;
                r_d.hit  = grade;
            end else begin
                r_d.fcnt = r_q.fcnt + NS_W'(1);
                r_d.acc  = sum_sat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign blk_done = r_q.done;
    assign blk_hit  = r_q.hit;

    // R8: a full accumulator stays full while frames keep arriving in the block
    assert_acc_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !restart && !last_frame && r_q.acc == ACC_MAX)
        |=> (r_q.acc == ACC_MAX));

endmodule

// File: rtl/ber_win_ctr.sv
// Window of blocks: counts blocks and hits, fires the state change trigger.
module ber_win_ctr #(
    parameter int M_W = 8,
    parameter int B_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blk_done,
    input  logic           blk_hit,
    input  logic [M_W-1:0] m_need,
    input  logic [B_W-1:0] b_len,
    output logic           trigger
);
    typedef struct packed {
        logic [B_W-1:0] blks;
        logic [M_W-1:0] hits;
    } win_t;

    win_t w_q, w_d;

    logic [M_W:0] hits_n;
    logic [B_W:0] blks_n;
    logic         fire;
    logic         expire;

    always_comb begin
        hits_n = {1'b0, w_q.hits} + (M_W+1)'(blk_hit);
        blks_n = {1'b0, w_q.blks} + (B_W+1)'(1);
        fire   = blk_done && blk_hit && (hits_n >= {1'b0, m_need});
        expire = blk_done && !fire && (blks_n >= {1'b0, b_len});

        w_d = w_q;
        if (fire || expire) begin
            w_d.blks = '0;
            w_d.hits = '0;
        end else if (blk_done) begin
            w_d.blks = blks_n[B_W-1:0];
            w_d.hits = hits_n[M_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign trigger = fire;

    // R4: the window restarts empty after every state change
    assert_win_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (w_q.hits == '0 && w_q.blks == '0));

endmodule

// File: rtl/ber_state_ctl.sv
// Alarm state register, sticky change flag and masked interrupt.
module ber_state_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic flag_clr,
    input  logic flag_mask,
    output logic alarm,
    output logic chg_flag,
    output logic irq
);
    import ber_hyst_pkg::*;

    typedef struct packed {
        ber_state_e st;
        logic       chg;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (trigger) begin
            s_d.st  = (s_q.st == ST_IDLE) ? ST_ALARM : ST_IDLE;
            s_d.chg = 1'b1;
        end else if (flag_clr) begin
            s_d.chg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.chg <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alarm    = (s_q.st == ST_ALARM);
    assign chg_flag = s_q.chg;
    assign irq      = s_q.chg & ~flag_mask;

    // R6: the flag holds until a clear pulse arrives
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !flag_clr) |=> chg_flag);

    // R6: any movement of the alarm leaves the flag set
    assert_flag_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm != $past(alarm)) |-> chg_flag);

endmodule

// File: rtl/ber_hyst_detector.sv
module ber_hyst_detector #(
    parameter int ERR_W = ber_hyst_pkg::DEF_ERR_W,
    parameter int L_W   = ber_hyst_pkg::DEF_L_W,
    parameter int NS_W  = ber_hyst_pkg::DEF_NS_W,
    parameter int M_W   = ber_hyst_pkg::DEF_M_W,
    parameter int B_W   = ber_hyst_pkg::DEF_B_W,
    parameter int ACC_W = ber_hyst_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [ERR_W-1:0] err_sec,
    input  logic [ERR_W-1:0] err_line,
    input  logic             src_sel,
    input  logic [L_W-1:0]   set_thresh,
    input  logic [NS_W-1:0]  set_frames,
    input  logic [M_W-1:0]   set_hits,
    input  logic [B_W-1:0]   set_blocks,
    input  logic [L_W-1:0]   clr_thresh,
    input  logic [NS_W-1:0]  clr_frames,
    input  logic [M_W-1:0]   clr_hits,
    input  logic [B_W-1:0]   clr_blocks,
    input  logic             chg_clr,
    input  logic             chg_mask,
    output logic             alarm,
    output logic             chg_flag,
    output logic             irq
);
    logic [ERR_W-1:0] err_sel;
    logic [NS_W-1:0]  ns_eff;
    logic [L_W-1:0]   l_eff;
    logic [M_W-1:0]   m_eff;
    logic [B_W-1:0]   b_eff;
    logic             blk_done;
    logic             blk_hit;
    logic             trigger;

    generate
        if (ACC_W < ERR_W || ACC_W < L_W) begin : g_bad_acc
            initial $error("ACC_W must cover ERR_W and L_W");
        end
    endgenerate

    always_comb begin
        err_sel = src_sel ? err_line : err_sec;
        if (alarm) begin
            l_eff  = clr_thresh;
            ns_eff = (clr_frames == '0) ? NS_W'(1) : clr_frames;
            m_eff  = (clr_hits   == '0) ? M_W'(1)  : clr_hits;
            b_eff  = (clr_blocks == '0) ? B_W'(1)  : clr_blocks;
        end else begin
            l_eff  = set_thresh;
            ns_eff = (set_frames == '0) ? NS_W'(1) : set_frames;
            m_eff  = (set_hits   == '0) ? M_W'(1)  : set_hits;
            b_eff  = (set_blocks == '0) ? B_W'(1)  : set_blocks;
        end
    end

    ber_blk_acc #(.ERR_W(ERR_W), .NS_W(NS_W), .L_W(L_W), .ACC_W(ACC_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .restart(trigger), .frame_stb(frame_stb),
        .err(err_sel), .ns_len(ns_eff), .l_thr(l_eff), .in_alarm(alarm),
        .blk_done(blk_done), .blk_hit(blk_hit)
    );

    ber_win_ctr #(.M_W(M_W), .B_W(B_W)) u_win (
        .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .blk_hit(blk_hit),
        .m_need(m_eff), .b_len(b_eff), .trigger(trigger)
    );

    ber_state_ctl u_st (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .flag_clr(chg_clr),
        .flag_mask(chg_mask), .alarm(alarm), .chg_flag(chg_flag), .irq(irq)
    );

    // R7: a masked flag never reaches the interrupt
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!chg_mask && chg_flag));

endmodule

// File: tb/sim_ber_hyst_detector.sv
module sim_ber_hyst_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [4:0]  err_sec = '0, err_line = '0;
    logic        src_sel = 1'b0;
    logic [3:0]  set_thresh = 4'd3, clr_thresh = 4'd2;
    logic [18:0] set_frames = 19'd2, clr_frames = 19'd3;
    logic [7:0]  set_hits = 8'd2, clr_hits = 8'd2;
    logic [11:0] set_blocks = 12'd3, clr_blocks = 12'd2;
    logic        chg_clr = 1'b0, chg_mask = 1'b0;
    logic        alarm, chg_flag, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic  a;
        logic  f;
        logic  i;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    ber_hyst_detector u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .err_sec(err_sec), .err_line(err_line), .src_sel(src_sel),
        .set_thresh(set_thresh), .set_frames(set_frames),
        .set_hits(set_hits), .set_blocks(set_blocks),
        .clr_thresh(clr_thresh), .clr_frames(clr_frames),
        .clr_hits(clr_hits), .clr_blocks(clr_blocks),
        .chg_clr(chg_clr), .chg_mask(chg_mask),
        .alarm(alarm), .chg_flag(chg_flag), .irq(irq)
    );

    task automatic push(input logic a, input logic f, input logic i, input string tag);
        exp_t e;
        e.a = a; e.f = f; e.i = i; e.tag = tag;
        sb.push_back(e);
    endtask

    // one frame, then expectation for the state after the deciding edge
    task automatic frame(input logic [4:0] es, input logic [4:0] el,
                         input logic a, input logic f, input logic i, input string tag);
        @(negedge clk);
        err_sec = es; err_line = el; frame_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        @(posedge clk);
        #1;
        push(a, f, i, tag);
    endtask

    task automatic clear_flag(input logic a, input logic i, input string tag);
        @(negedge clk);
        chg_clr = 1'b1;
        @(negedge clk);
        chg_clr = 1'b0;
        push(a, 1'b0, i, tag);
    endtask

    task automatic set_mask(input logic m, input logic a, input logic f, input logic i,
                            input string tag);
        @(negedge clk);
        chg_mask = m;
        @(posedge clk);
        #1;
        push(a, f, i, tag);
    endtask

    // monitor: compare each expected item at the following falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (alarm !== e.a || chg_flag !== e.f || irq !== e.i) begin
                    errors++;
                    $display("FAIL %s: alarm/flag/irq = %b%b%b expected %b%b%b",
                             e.tag, alarm, chg_flag, irq, e.a, e.f, e.i);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push(1'b0, 1'b0, 1'b0, "R10 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // declare with section parity; line input carries noise that must not count (R1, R5)
        frame(5'd2, 5'd0,  0, 0, 0, "R1 blk1 f1");
        frame(5'd1, 5'd0,  0, 0, 0, "R1 blk1 hit");
        frame(5'd2, 5'd31, 0, 0, 0, "R5 line ignored");
        frame(5'd2, 5'd31, 1, 1, 1, "R1 R10 declare on 2nd hit");
        clear_flag(1, 0, "R6 flag cleared");

        // removal: block A good, no carried hits (R4)
        frame(5'd1, 5'd0, 1, 0, 0, "R3 a1");
        frame(5'd0, 5'd0, 1, 0, 0, "R3 a2");
        frame(5'd0, 5'd0, 1, 0, 0, "R4 hit count restarted");
        // block B sum 2 is not below 2: window of 2 expires
        frame(5'd0, 5'd0, 1, 0, 0, "R3 b1");
        frame(5'd1, 5'd0, 1, 0, 0, "R3 b2");
        frame(5'd1, 5'd0, 1, 0, 0, "R3 b3 miss");
        // block C good: only first hit of fresh window
        frame(5'd0, 5'd0, 1, 0, 0, "R2 c1");
        frame(5'd0, 5'd0, 1, 0, 0, "R2 c2");
        frame(5'd0, 5'd0, 1, 0, 0, "R2 clear window expired");
        // block D good: second hit, alarm removed
        frame(5'd0, 5'd0, 1, 0, 0, "R3 d1");
        frame(5'd0, 5'd0, 1, 0, 0, "R3 d2");
        frame(5'd1, 5'd0, 0, 1, 1, "R3 removed");

        set_mask(1'b1, 0, 1, 0, "R7 masked");
        clear_flag(0, 0, "R6 flag cleared masked");

        // declare via line parity, section input heavy but unselected
        src_sel = 1'b1;
        frame(5'd9, 5'd3, 0, 0, 0, "R5 s1");
        frame(5'd9, 5'd0, 0, 0, 0, "R5 blk1 hit");
        frame(5'd9, 5'd0, 0, 0, 0, "R5 s3");
        frame(5'd9, 5'd0, 0, 0, 0, "R5 section ignored");
        frame(5'd0, 5'd0, 0, 0, 0, "R2 s5");
        frame(5'd0, 5'd0, 0, 0, 0, "R2 set window expired");
        frame(5'd0, 5'd0, 0, 0, 0, "R2 s7");
        frame(5'd0, 5'd3, 0, 0, 0, "R2 first hit new window");
        frame(5'd0, 5'd2, 0, 0, 0, "R1 s9");
        frame(5'd0, 5'd1, 1, 1, 0, "R1 R5 declare masked");
        clear_flag(1, 0, "R6 flag cleared");
        set_mask(1'b0, 1, 0, 0, "R7 unmasked idle");

        // saturation: 9 x 29 = 261 wraps to 5, saturates to 255
        clr_frames = 19'd9; clr_thresh = 4'd15; clr_hits = 8'd1; clr_blocks = 12'd1;
        for (int k = 0; k < 8; k++) frame(5'd0, 5'd29, 1, 0, 0, "R8 fill");
        frame(5'd0, 5'd29, 1, 0, 0, "R8 saturated sum not below 15");
        for (int k = 0; k < 8; k++) frame(5'd0, 5'd0, 1, 0, 0, "R3 quiet");
        frame(5'd0, 5'd0, 0, 1, 1, "R3 removed single hit");
        clear_flag(0, 0, "R6 flag cleared");

        // zero-valued set parameters act as one
        set_frames = 19'd0; set_hits = 8'd0; set_blocks = 12'd0; set_thresh = 4'd1;
        frame(5'd0, 5'd1, 1, 1, 1, "R9 zero params declare");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule